// File: doc/BRIEF.md
# Fetch-Line Clustered Branch Target Buffer

This block gives the front end one prediction for each 16-byte aligned fetch line. A lookup splits the fetch IP into three fields: a line offset, a set index and a tag. It reads the four ways of the indexed set in the same cycle. A way counts as a candidate when its tag matches and its stored branch offset is at or beyond the fetch offset. Of the candidates predicted taken, the one with the lowest offset supplies the next fetch IP. When no candidate is predicted taken, the output is the start of the next sequential line.

Direction for conditional branches comes from a table of 2-bit saturating counters. The table is held per set and indexed by the 4-bit local history stored in each entry. Unconditional branches, calls and returns are always predicted taken. When a conditional branch wins a lookup, its history is shifted on the spot. A later resolve request overwrites that history with the true outcome and trains the counter it used. A resolve request that finds no entry allocates a way at a round-robin pointer kept per set.

Top module: `fetch_line_btb`

## Requirements
- R1: After reset every entry is invalid, and every lookup reports not taken.
- R2: The IP fields are offset = ip[3:0], set = ip[10:4] and tag = ip[31:11]. A way is a candidate only when it is valid and both its set and its tag equal those of the fetch IP.
- R3: When no candidate is predicted taken, pr_taken is 0 and pr_next_ip = (ip with bits [3:0] cleared) + 16. pr_way, pr_kind and pr_hist are 0 in that case.
- R4: A way whose stored offset is below the fetch offset is dropped. A way whose stored offset equals the fetch offset is kept.
- R5: Among the candidates predicted taken, the way with the lowest stored offset wins. Its target drives pr_next_ip, and pr_way, pr_kind and pr_hist report its way number, kind and history.
- R6: The kind encoding is 0 conditional, 1 return, 2 call, 3 unconditional. Kinds 1, 2 and 3 are predicted taken whatever their counter holds.
- R7: A conditional branch is predicted taken when bit 1 of counter [set][entry history] is 1. Counters reset to 1 and saturate at 0 and 3.
- R8: A resolve request that hits (same tag, set and offset) does four things. It rewrites the target and the kind. It moves counter [set][up_hist] up when up_taken is 1 and down otherwise. It sets the entry history to {up_hist[2:0], up_taken}. It leaves the replacement pointer unchanged.
- R9: A lookup whose winner is conditional shifts a 1 into the low end of that entry's history at the clock edge. pr_hist shows the history from before the shift.
- R10: A resolve request that misses writes the way chosen by the set's pointer, which starts at 0. The new entry's history is 0, and no counter changes. The pointer then steps up by one modulo 4.
- R11: When a resolve request and a speculative shift hit the same entry in the same cycle, the resolve request's history is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request for this cycle |
| lk_ip | input | 32 | Fetch IP |
| up_valid | input | 1 | Resolve request |
| up_ip | input | 32 | IP of the resolved branch |
| up_target | input | 32 | Resolved target |
| up_kind | input | 2 | Branch kind (0 conditional, 1 return, 2 call, 3 unconditional) |
| up_taken | input | 1 | Resolved direction |
| up_hist | input | 4 | History the branch was predicted with (the pr_hist of that lookup) |
| pr_taken | output | 1 | A taken branch was found in the fetch line |
| pr_next_ip | output | 32 | Predicted next fetch IP |
| pr_way | output | 2 | Winning way |
| pr_kind | output | 2 | Kind of the winning branch |
| pr_hist | output | 4 | History of the winning entry before any shift |

## Verification
The hardest case to reach is a conditional entry whose own history points at a counter that has been trained taken. Resolve requests write the history as the supplied history shifted by one bit, and they train the counter at the supplied history, not the one at the result. The stimulus therefore picks the supplied histories to steer this. A supplied history of 1111 trains the very counter the entry then reads. A supplied history of 0111 moves the entry onto 1111 without touching counter 1111, which lets counter saturation be seen through a later lookup. The same trick is used in the collision case: one cycle carries both a committing lookup and a resolve request to the same entry. The two outcomes lead to different next IPs.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef enum logic [1:0] {
      BR_COND = 2'b00,
      BR_RET  = 2'b01,
      BR_CALL = 2'b10,
      BR_JMP  = 2'b11
   } br_kind_e;

   // Saturating step of a 2-bit direction counter
   function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
      logic [1:0] n;
      if (up) n = (c == 2'b11) ? c : c + 2'b01;
      else    n = (c == 2'b00) ? c : c - 2'b01;
      return n;
   endfunction

endpackage

// File: rtl/btb_way_qual.sv
module btb_way_qual
   import btb_pkg::*;
#(
   parameter int TAG_W = 21,
   parameter int OFS_W = 4,
   parameter bit NONCOND_ALWAYS_TAKEN = 1'b1
) (
   input  logic             valid,
   input  logic [TAG_W-1:0] tag_store,
   input  logic [TAG_W-1:0] tag_req,
   input  logic [OFS_W-1:0] ofs_store,
   input  logic [OFS_W-1:0] ofs_req,
   input  logic [1:0]       kind,
   input  logic [1:0]       ctr,
   output logic             qual
);

   logic tag_hit;
   logic reach;
   logic dir_taken;

   assign tag_hit = valid && (tag_store == tag_req);
   assign reach   = (ofs_store >= ofs_req);

   generate
      if (NONCOND_ALWAYS_TAKEN) begin : g_static
         assign dir_taken = (kind != BR_COND) || ctr[1];
      end else begin : g_dynamic
         assign dir_taken = ctr[1];
      end
   endgenerate

   assign qual = tag_hit && reach && dir_taken;

endmodule

// File: rtl/btb_dir_ctrs.sv
module btb_dir_ctrs
   import btb_pkg::*;
#(
   parameter int SET_W  = 7,
   parameter int HIST_W = 4,
   parameter int PORTS  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SET_W-1:0]              rd_set,
   input  logic [PORTS-1:0][HIST_W-1:0]  rd_hist,
   output logic [PORTS-1:0][1:0]         rd_ctr,
   input  logic                          wr_en,
   input  logic [SET_W-1:0]              wr_set,
   input  logic [HIST_W-1:0]             wr_hist,
   input  logic                          wr_up
);

   localparam int CIDX_W = SET_W + HIST_W;
   localparam int NCTR   = 1 << CIDX_W;

   logic [1:0] ctr [NCTR];
   logic [CIDX_W-1:0] widx;

   assign widx = {wr_set, wr_hist};

   initial begin
      assert (HIST_W >= 2) else $error("history must be at least 2 bits");
   end

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_rd
         assign rd_ctr[p] = ctr[{rd_set, rd_hist[p]}];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCTR; i++) ctr[i] <= 2'b01;
      end else if (wr_en) begin
         ctr[widx] <= ctr_step(ctr[widx], wr_up);
      end
   end

   // R7: counters stop at both ends
   a_r7_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_up && ctr[widx] == 2'b11) |=> (ctr[$past(widx)] == 2'b11));
   a_r7_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_up && ctr[widx] == 2'b00) |=> (ctr[$past(widx)] == 2'b00));

endmodule

// File: rtl/btb_first_pick.sv
module btb_first_pick #(
   parameter int WAYS  = 4,
   parameter int OFS_W = 4,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [WAYS-1:0]             qual,
   input  logic [WAYS-1:0][OFS_W-1:0]  ofs,
   output logic                        found,
   output logic [WAY_W-1:0]            sel
);

   logic [OFS_W-1:0] best;

   always_comb begin
      found = 1'b0;
      sel   = '0;
      best  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (qual[w] && (!found || ofs[w] < best)) begin
            found = 1'b1;
            sel   = WAY_W'(w);
            best  = ofs[w];
         end
      end
   end

   // R5: the chosen way qualifies, and no qualifying way sits lower in the line
   a_r5_sel_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> qual[sel]);
   a_r3_none_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (qual == '0));

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_min
         a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
            (found && qual[w]) |-> (ofs[sel] <= ofs[w]));
      end
   endgenerate

endmodule

// File: rtl/fetch_line_btb.sv
module fetch_line_btb
   import btb_pkg::*;
#(
   parameter int IP_W   = 32,
   parameter int OFS_W  = 4,
   parameter int SET_W  = 7,
   parameter int WAYS   = 4,
   parameter int HIST_W = 4,
   parameter bit NONCOND_ALWAYS_TAKEN = 1'b1,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [IP_W-1:0]   lk_ip,
   input  logic              up_valid,
   input  logic [IP_W-1:0]   up_ip,
   input  logic [IP_W-1:0]   up_target,
   input  logic [1:0]        up_kind,
   input  logic              up_taken,
   input  logic [HIST_W-1:0] up_hist,
   output logic              pr_taken,
   output logic [IP_W-1:0]   pr_next_ip,
   output logic [WAY_W-1:0]  pr_way,
   output logic [1:0]        pr_kind,
   output logic [HIST_W-1:0] pr_hist
);

   localparam int SETS    = 1 << SET_W;
   localparam int TAG_W   = IP_W - OFS_W - SET_W;
   localparam int ENTRIES = SETS * WAYS;
   localparam int IDX_W   = SET_W + WAY_W;
   localparam int LINE_W  = IP_W - OFS_W;

   initial begin
      assert (IP_W > OFS_W + SET_W) else $error("IP too narrow for offset and set");
      assert (WAYS == (1 << WAY_W)) else $error("ways must be a power of two");
      assert (HIST_W >= 2) else $error("history must be at least 2 bits");
   end

   function automatic logic [IDX_W-1:0] slot(input logic [SET_W-1:0] s,
                                             input logic [WAY_W-1:0] w);
      return {s, w};
   endfunction

   // entry storage
   logic              e_vld  [ENTRIES];
   logic [TAG_W-1:0]  e_tag  [ENTRIES];
   logic [OFS_W-1:0]  e_ofs  [ENTRIES];
   logic [1:0]        e_kind [ENTRIES];
   logic [HIST_W-1:0] e_hist [ENTRIES];
   logic [IP_W-1:0]   e_tgt  [ENTRIES];
   logic [WAY_W-1:0]  rptr   [SETS];

   // lookup fields
   logic [OFS_W-1:0] lk_ofs;
   logic [SET_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   assign lk_ofs = lk_ip[OFS_W-1:0];
   assign lk_set = lk_ip[OFS_W+SET_W-1:OFS_W];
   assign lk_tag = lk_ip[IP_W-1:OFS_W+SET_W];

   // resolve fields
   logic [OFS_W-1:0] up_ofs;
   logic [SET_W-1:0] up_set;
   logic [TAG_W-1:0] up_tag;
   assign up_ofs = up_ip[OFS_W-1:0];
   assign up_set = up_ip[OFS_W+SET_W-1:OFS_W];
   assign up_tag = up_ip[IP_W-1:OFS_W+SET_W];

   logic [WAYS-1:0]              lk_qual;
   logic [WAYS-1:0][HIST_W-1:0]  lk_hists;
   logic [WAYS-1:0][1:0]         lk_ctr;
   logic [WAYS-1:0][OFS_W-1:0]   lk_ofs_w;
   logic [WAYS-1:0]              up_match;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         localparam logic [WAY_W-1:0] WID = WAY_W'(w);
         assign lk_hists[w] = e_hist[slot(lk_set, WID)];
         assign lk_ofs_w[w] = e_ofs[slot(lk_set, WID)];
         assign up_match[w] = e_vld[slot(up_set, WID)]
                              && (e_tag[slot(up_set, WID)] == up_tag)
                              && (e_ofs[slot(up_set, WID)] == up_ofs);

         btb_way_qual #(
            .TAG_W(TAG_W),
            .OFS_W(OFS_W),
            .NONCOND_ALWAYS_TAKEN(NONCOND_ALWAYS_TAKEN)
         ) u_qual (
            .valid    (e_vld[slot(lk_set, WID)]),
            .tag_store(e_tag[slot(lk_set, WID)]),
            .tag_req  (lk_tag),
            .ofs_store(lk_ofs_w[w]),
            .ofs_req  (lk_ofs),
            .kind     (e_kind[slot(lk_set, WID)]),
            .ctr      (lk_ctr[w]),
            .qual     (lk_qual[w])
         );
      end
   endgenerate

   // resolve-side hit detection
   logic             up_hit;
   logic [WAY_W-1:0] up_hit_way;
   always_comb begin
      up_hit     = 1'b0;
      up_hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (up_match[w] && !up_hit) begin
            up_hit     = 1'b1;
            up_hit_way = WAY_W'(w);
         end
      end
   end

   btb_dir_ctrs #(
      .SET_W (SET_W),
      .HIST_W(HIST_W),
      .PORTS (WAYS)
   ) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_set (lk_set),
      .rd_hist(lk_hists),
      .rd_ctr (lk_ctr),
      .wr_en  (up_valid && up_hit),
      .wr_set (up_set),
      .wr_hist(up_hist),
      .wr_up  (up_taken)
   );

   logic             lk_found;
   logic [WAY_W-1:0] lk_sel;

   btb_first_pick #(
      .WAYS (WAYS),
      .OFS_W(OFS_W)
   ) u_pick (
      .clk  (clk),
      .rst_n(rst_n),
      .qual (lk_qual),
      .ofs  (lk_ofs_w),
      .found(lk_found),
      .sel  (lk_sel)
   );

   logic [IDX_W-1:0] win_idx;
   logic             spec_we;
   logic [WAY_W-1:0] up_way;
   logic [IDX_W-1:0] up_idx;
   logic [IP_W-1:0]  seq_ip;

   assign win_idx = slot(lk_set, lk_sel);
   assign spec_we = lk_valid && lk_found && (e_kind[win_idx] == BR_COND);
   assign up_way  = up_hit ? up_hit_way : rptr[up_set];
   assign up_idx  = slot(up_set, up_way);
   assign seq_ip  = {lk_ip[IP_W-1:OFS_W] + LINE_W'(1), {OFS_W{1'b0}}};

   // state with reset: valid bits, histories, replacement pointers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            e_vld[i]  <= 1'b0;
            e_hist[i] <= '0;
         end
         for (int s = 0; s < SETS; s++) rptr[s] <= '0;
      end else begin
         if (spec_we)
            e_hist[win_idx] <= {e_hist[win_idx][HIST_W-2:0], 1'b1};
         if (up_valid) begin
            e_vld[up_idx]  <= 1'b1;
            e_hist[up_idx] <= up_hit ? {up_hist[HIST_W-2:0], up_taken} : '0;
            if (!up_hit)
               rptr[up_set] <= rptr[up_set] + WAY_W'(1);
         end
      end
   end

   // payload without reset
   always_ff @(posedge clk) begin
      if (up_valid) begin
         e_tag[up_idx]  <= up_tag;
         e_ofs[up_idx]  <= up_ofs;
         e_kind[up_idx] <= up_kind;
         e_tgt[up_idx]  <= up_target;
      end
   end

   assign pr_taken   = lk_valid && lk_found;
   assign pr_next_ip = pr_taken ? e_tgt[win_idx] : seq_ip;
   assign pr_way     = pr_taken ? lk_sel : '0;
   assign pr_kind    = pr_taken ? e_kind[win_idx] : 2'b00;
   assign pr_hist    = pr_taken ? e_hist[win_idx] : '0;

   // R10: a miss moves the set's pointer by one
   a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_hit) |=> (rptr[$past(up_set)] == $past(rptr[up_set]) + WAY_W'(1)));
   // R8: a hit leaves the pointer alone
   a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_hit) |=> (rptr[$past(up_set)] == $past(rptr[up_set])));
   // R3: a sequential prediction is line aligned
   a_r3_seq_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !pr_taken) |-> (pr_next_ip[OFS_W-1:0] == '0));
   // R1: no lookup, no taken prediction
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !pr_taken);

endmodule

// File: tb/fetch_line_btb_bench.sv
`timescale 1ns/1ps
module fetch_line_btb_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_ip = '0;
   logic        up_valid = 1'b0;
   logic [31:0] up_ip = '0;
   logic [31:0] up_target = '0;
   logic [1:0]  up_kind = '0;
   logic        up_taken = 1'b0;
   logic [3:0]  up_hist = '0;
   logic        pr_taken;
   logic [31:0] pr_next_ip;
   logic [1:0]  pr_way;
   logic [1:0]  pr_kind;
   logic [3:0]  pr_hist;

   int total = 0;
   int bad = 0;

   logic        o_taken;
   logic [31:0] o_next;
   logic [1:0]  o_way;
   logic [1:0]  o_kind;
   logic [3:0]  o_hist;

   localparam logic [1:0] K_COND = 2'd0, K_RET = 2'd1, K_CALL = 2'd2, K_JMP = 2'd3;
   localparam logic [20:0] TA = 21'h0ABCD, TB = 21'h01234;
   localparam logic [31:0] T1 = 32'h0000_4000, T2 = 32'h0000_5000, T3 = 32'h0000_6000,
                           T4 = 32'h0000_7000, T5 = 32'h0000_8000, T6 = 32'h0000_9000;

   always #2 clk = ~clk;

   fetch_line_btb u_fetch_line_btb (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_ip(lk_ip),
      .up_valid(up_valid), .up_ip(up_ip), .up_target(up_target),
      .up_kind(up_kind), .up_taken(up_taken), .up_hist(up_hist),
      .pr_taken(pr_taken), .pr_next_ip(pr_next_ip), .pr_way(pr_way),
      .pr_kind(pr_kind), .pr_hist(pr_hist)
   );

   function automatic logic [31:0] mk(input logic [20:0] t, input logic [6:0] s, input logic [3:0] o);
      return {t, s, o};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic probe(input logic [31:0] ip, input bit commit);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_ip    = ip;
      #1;
      o_taken = pr_taken; o_next = pr_next_ip; o_way = pr_way;
      o_kind  = pr_kind;  o_hist = pr_hist;
      if (commit) begin
         @(posedge clk);
         #1;
      end
      lk_valid = 1'b0;
   endtask

   task automatic resolve(input logic [31:0] ip, input logic [31:0] tgt, input logic [1:0] kind,
                          input logic tk, input logic [3:0] h);
      @(negedge clk);
      up_valid = 1'b1; up_ip = ip; up_target = tgt; up_kind = kind;
      up_taken = tk; up_hist = h;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic expect_taken(input string req, input logic [31:0] tgt, input logic [1:0] way,
                               input logic [1:0] kind);
      chk(req, "taken", {31'b0, o_taken}, 32'd1);
      chk(req, "next ip", o_next, tgt);
      chk(req, "way", {30'b0, o_way}, {30'b0, way});
      chk(req, "kind", {30'b0, o_kind}, {30'b0, kind});
   endtask

   task automatic expect_seq(input string req, input logic [31:0] ip);
      chk(req, "taken", {31'b0, o_taken}, 32'd0);
      chk(req, "next ip", o_next, {ip[31:4], 4'b0} + 32'd16);
   endtask

   task automatic t_reset;
      probe(32'h1234_5678, 1'b0);
      expect_seq("R1", 32'h1234_5678);
      chk("R3", "way zero", {30'b0, o_way}, 32'd0);
      chk("R3", "hist zero", {28'b0, o_hist}, 32'd0);
   endtask

   task automatic t_alloc_fields;
      resolve(mk(TA, 7'd5, 4'd8), T1, K_JMP, 1'b1, 4'h0);
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R10", T1, 2'd0, K_JMP);
      probe(mk(TA, 7'd5, 4'd8), 1'b0);
      expect_taken("R4", T1, 2'd0, K_JMP);
      probe(mk(TA, 7'd5, 4'd9), 1'b0);
      expect_seq("R4", mk(TA, 7'd5, 4'd9));
      probe(mk(TB, 7'd5, 4'd0), 1'b0);
      expect_seq("R2", mk(TB, 7'd5, 4'd0));
      probe(mk(TA, 7'd6, 4'd0), 1'b0);
      expect_seq("R2", mk(TA, 7'd6, 4'd0));
   endtask

   task automatic t_order;
      resolve(mk(TA, 7'd5, 4'd3), T2, K_JMP, 1'b1, 4'h0);
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R5", T2, 2'd1, K_JMP);
      probe(mk(TA, 7'd5, 4'd4), 1'b0);
      expect_taken("R5", T1, 2'd0, K_JMP);
   endtask

   task automatic t_cond;
      resolve(mk(TA, 7'd5, 4'd1), T3, K_COND, 1'b1, 4'h0);
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R7", T2, 2'd1, K_JMP);            // fresh counter 01 -> not taken
      resolve(mk(TA, 7'd5, 4'd1), T3, K_COND, 1'b1, 4'hF);
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R8", T3, 2'd2, K_COND);
      chk("R8", "hist", {28'b0, o_hist}, 32'hF);
      // saturation: counter F to 11, then one step down stays taken
      resolve(mk(TA, 7'd5, 4'd1), T3, K_COND, 1'b1, 4'hF);
      resolve(mk(TA, 7'd5, 4'd1), T3, K_COND, 1'b1, 4'hF);
      resolve(mk(TA, 7'd5, 4'd1), T3, K_COND, 1'b0, 4'hF);
      resolve(mk(TA, 7'd5, 4'd1), T3, K_COND, 1'b1, 4'h7); // history back to F
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R7", T3, 2'd2, K_COND);
   endtask

   task automatic t_spec;
      resolve(mk(TA, 7'd5, 4'd1), T3, K_COND, 1'b1, 4'h3); // counter 3 up, hist 7
      probe(mk(TA, 7'd5, 4'd0), 1'b1);
      expect_taken("R9", T3, 2'd2, K_COND);
      chk("R9", "hist before shift", {28'b0, o_hist}, 32'h7);
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      chk("R9", "hist after shift", {28'b0, o_hist}, 32'hF);
   endtask

   task automatic t_collide;
      @(negedge clk);
      up_valid = 1'b1; up_ip = mk(TA, 7'd5, 4'd1); up_target = T3; up_kind = K_COND;
      up_taken = 1'b0; up_hist = 4'h0;
      lk_valid = 1'b1; lk_ip = mk(TA, 7'd5, 4'd0);
      @(negedge clk);
      up_valid = 1'b0; lk_valid = 1'b0;
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R11", T2, 2'd1, K_JMP);
   endtask

   task automatic t_kinds;
      resolve(mk(TA, 7'd9, 4'd2), T4, K_RET, 1'b0, 4'h0);
      probe(mk(TA, 7'd9, 4'd0), 1'b0);
      expect_taken("R6", T4, 2'd0, K_RET);
      resolve(mk(TA, 7'd9, 4'd1), T5, K_CALL, 1'b0, 4'h0);
      probe(mk(TA, 7'd9, 4'd0), 1'b0);
      expect_taken("R6", T5, 2'd1, K_CALL);
      resolve(mk(TA, 7'd9, 4'd0), T6, K_COND, 1'b0, 4'h0);
      probe(mk(TA, 7'd9, 4'd0), 1'b0);
      expect_taken("R6", T5, 2'd1, K_CALL);
   endtask

   task automatic t_wrap;
      resolve(mk(TA, 7'd5, 4'd14), T4, K_JMP, 1'b1, 4'h0);
      probe(mk(TA, 7'd5, 4'd13), 1'b0);
      expect_taken("R10", T4, 2'd3, K_JMP);
      resolve(mk(TA, 7'd5, 4'd12), T5, K_JMP, 1'b1, 4'h0);
      probe(mk(TA, 7'd5, 4'd4), 1'b0);
      expect_taken("R10", T5, 2'd0, K_JMP);
      probe(mk(TA, 7'd5, 4'd8), 1'b0);
      expect_taken("R10", T5, 2'd0, K_JMP);
   endtask

   task automatic t_retarget;
      resolve(mk(TA, 7'd5, 4'd3), T6, K_JMP, 1'b1, 4'h0);
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R8", T6, 2'd1, K_JMP);
      resolve(mk(TB, 7'd5, 4'd5), T1, K_JMP, 1'b1, 4'h0); // pointer still at way 1
      probe(mk(TB, 7'd5, 4'd0), 1'b0);
      expect_taken("R8", T1, 2'd1, K_JMP);
      probe(mk(TA, 7'd5, 4'd0), 1'b0);
      expect_taken("R8", T5, 2'd0, K_JMP);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_alloc_fields();
      t_order();
      t_cond();
      t_spec();
      t_collide();
      t_kinds();
      t_wrap();
      t_retarget();
      repeat (2) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule